// File: doc/BRIEF.md
# Multi-channel PWM timer

The block is a pulse-width modulator built around a prescaled timer counter. Seven match registers are compared against the counter. Six outputs are driven from the match events. Match 0 normally closes the period: it resets the counter, and it starts the high phase of every output that is in single-edge mode. An output k in double-edge mode rises on match k-1 and falls on match k. This lets the pulse sit anywhere in the period.

Software writes new match values into shadow copies. A shadow copy reaches the comparator only when its load-enable bit is set. The copy is made at the next period boundary, so a waveform never changes partway through a period.

Each match can be set to raise an interrupt flag, to reset the counter, or to stop the counter. Instead of counting prescaled clock cycles, the counter can count edges of a selected external input. Two capture flag inputs also feed the interrupt flag register.

Top module: `pwm_timer`

## Requirements
- R1: The register map uses word addresses. 0 is the interrupt flags, 1 is timer control, 2 is the counter value (read only), 3 is the prescale limit, 4 is the prescale count (read only), 5 is match control, 6 is output control, 7 is load enable, and 8 is count control. Addresses 16+n are the shadow of match n, for n from 0 to 6; reading one returns the shadow value. After reset every register reads 0, and pwm_o and irq_o are 0.
- R2: Timer control works as follows. Bit 0 enables counting. Bit 1, while it is set, holds the counter and the prescale count at 0.
- R3: In timer mode the prescale count runs from 0 up to the prescale limit. Each time it wraps, the counter is ticked once, so a limit of P gives one tick every P+1 cycles. At a tick where the counter equals active match n, match event n fires. If the match control reset bit is set for any firing match, the counter goes to 0 instead of counting up.
- R4: Match control has three bits for each match n: bit 3n enables the interrupt, bit 3n+1 enables the counter reset, and bit 3n+2 enables the stop. On a stop event the counter and the prescale count keep their values, and the enable bit in timer control reads 0 from then on.
- R5: Output k, for k from 1 to 6, is driven low in the cycle after match event k.
- R6: An output in single-edge mode is driven high in the cycle after match event 0, unless its own clear match fires in the same event.
- R7: An output k in double-edge mode is driven high in the cycle after match event k-1 and low after match event k. Matches 4 and 5 therefore set outputs 5 and 6. Match 6 only clears output 6.
- R8: In output control, bit k-1 selects double-edge mode for output k. Bit k+7 enables output k. A disabled output stays at 0, while its internal waveform keeps running.
- R9: A write to a match address changes only the shadow copy. At a match 0 event whose reset bit is set, every match n whose load-enable bit n is set copies its shadow into the active comparator. All load-enable bits then read 0.
- R10: Count control bits [1:0] select the mode: 0 is timer, 1 counts rising edges, 2 counts falling edges, and 3 counts both. Bit 2 selects which counter input is used. Each counter input passes through two synchronising flops. In a counter mode every qualifying edge of the selected input ticks the counter once, and the prescaler does not take part. Edges on the other input have no effect.
- R11: Interrupt flag bit positions are as follows: match 0 to 3 at bits 0 to 3, capture 0 at bit 4, capture 1 at bit 5, and match 4 to 6 at bits 8 to 10. Bits 7:6 always read 0. A match event with its interrupt bit enabled sets its flag, and so does a cycle in which cap_i[0] or cap_i[1] is high. irq_o is high whenever any flag is set.
- R12: Writing a 1 to a flag bit clears that flag, and writing a 0 leaves it unchanged. A set that arrives in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i (combinational) |
| cnt_in_i | input | N_CNT_IN | External count inputs (asynchronous) |
| cap_i | input | 2 | Capture event flags 0 and 1 |
| pwm_o | output | 6 | PWM outputs 1 to 6 (bit k-1 is output k) |
| irq_o | output | 1 | Interrupt request, OR of all flags |

## Verification
The bench measures each output's high time over a whole number of periods. It does this for single-edge and double-edge channels, with and without the prescaler, and before and after a shadow load. An output whose set source or clear source was taken from the wrong match shows a different duty count. So does a channel whose shadow value leaked into the comparator before it was load-enabled.

Interrupt flags are checked for the bit 8 to 10 placement of the upper matches, for reserved bits that stay at 0, and for clearing that responds only to ones. Counting from the external input is checked per edge mode and per input select. A miscounted edge, or counting on the unselected input, leaves the wrong counter value. Stop is checked by reading the counter after the stop: a design that kept counting or kept its enable bit would show it.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int N_MATCH = 7;
  localparam int N_OUT   = 6;
  localparam int DW      = 32;
  localparam int AW      = 5;
  localparam int IR_W    = 11;
  localparam int MCR_W   = 3 * N_MATCH;

  localparam logic [AW-1:0] A_IR   = 5'd0;
  localparam logic [AW-1:0] A_TCR  = 5'd1;
  localparam logic [AW-1:0] A_TC   = 5'd2;
  localparam logic [AW-1:0] A_PR   = 5'd3;
  localparam logic [AW-1:0] A_PC   = 5'd4;
  localparam logic [AW-1:0] A_MCR  = 5'd5;
  localparam logic [AW-1:0] A_PCR  = 5'd6;
  localparam logic [AW-1:0] A_LER  = 5'd7;
  localparam logic [AW-1:0] A_CTCR = 5'd8;
  localparam logic [AW-1:0] A_MR0  = 5'd16;

  typedef enum logic [1:0] {
    CM_TIMER = 2'd0,
    CM_RISE  = 2'd1,
    CM_FALL  = 2'd2,
    CM_BOTH  = 2'd3
  } cmode_e;

  // flag position of match n: 0..3 low, 4..6 above the reserved pair
  function automatic int irq_pos(input int n);
    return (n < 4) ? n : n + 4;
  endfunction
endpackage

// File: rtl/pwm_cnt_src.sv
module pwm_cnt_src
  import pwm_pkg::*;
#(
  parameter int N_IN  = 2,
  parameter int SEL_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  cnt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  cmode_e           mode_i,
  output logic             edge_o
);
  logic [N_IN-1:0] s1_q, s2_q, s3_q;
  logic cur, prv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= cnt_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign cur = s2_q[sel_i];
  assign prv = s3_q[sel_i];

  always_comb begin
    unique case (mode_i)
      CM_RISE: edge_o = cur & ~prv;
      CM_FALL: edge_o = ~cur & prv;
      CM_BOTH: edge_o = cur ^ prv;
      default: edge_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             hold_i,
  input  logic             ext_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] pr_i,
  input  logic             rst_req_i,
  input  logic             stop_req_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] tc_o,
  output logic [CNT_W-1:0] pc_o
);
  logic [CNT_W-1:0] tc_q, pc_q;

  assign tick_o = en_i && !hold_i && (ext_i ? edge_i : (pc_q == pr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q <= '0;
      pc_q <= '0;
    end else if (hold_i) begin
      tc_q <= '0;
      pc_q <= '0;
    end else if (tick_o) begin
      if (!stop_req_i) begin
        tc_q <= rst_req_i ? '0 : tc_q + CNT_W'(1);
        pc_q <= '0;
      end
    end else if (en_i && !ext_i) begin
      pc_q <= pc_q + CNT_W'(1);
    end
  end

  assign tc_o = tc_q;
  assign pc_o = pc_q;
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank
  import pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_MATCH-1:0]              wr_i,
  input  logic [CNT_W-1:0]                wdata_i,
  input  logic [N_MATCH-1:0]              ler_i,
  input  logic                            load_i,
  input  logic                            tick_i,
  input  logic [CNT_W-1:0]                tc_i,
  output logic [N_MATCH-1:0][CNT_W-1:0]   shadow_o,
  output logic [N_MATCH-1:0]              match_o
);
  logic [N_MATCH-1:0][CNT_W-1:0] shd_q, act_q;

  for (genvar n = 0; n < N_MATCH; n++) begin : g_mr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_q[n] <= '0;
        act_q[n] <= '0;
      end else begin
        if (wr_i[n]) shd_q[n] <= wdata_i;
        if (load_i && ler_i[n]) act_q[n] <= shd_q[n];
      end
    end
    assign match_o[n] = tick_i && (tc_i == act_q[n]);
  end

  assign shadow_o = shd_q;
endmodule

// File: rtl/pwm_out_ctrl.sv
module pwm_out_ctrl
  import pwm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_MATCH-1:0] match_i,
  input  logic [N_OUT-1:0]   dbl_i,
  input  logic [N_OUT-1:0]   en_i,
  output logic [N_OUT-1:0]   state_o,
  output logic [N_OUT-1:0]   pwm_o
);
  logic [N_OUT-1:0] st_q;

  // output k+1: cleared by match k+1, set by match 0 or match k
  for (genvar k = 0; k < N_OUT; k++) begin : g_ch
    logic set_c, clr_c;
    assign set_c = dbl_i[k] ? match_i[k] : match_i[0];
    assign clr_c = match_i[k+1];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    st_q[k] <= 1'b0;
      else if (clr_c) st_q[k] <= 1'b0;
      else if (set_c) st_q[k] <= 1'b1;
    end
  end

  assign state_o = st_q;
  assign pwm_o   = st_q & en_i;
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int N_CNT_IN = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  input  logic [N_CNT_IN-1:0] cnt_in_i,
  input  logic [1:0]          cap_i,
  output logic [N_OUT-1:0]    pwm_o,
  output logic                irq_o
);
  localparam int SEL_W = (N_CNT_IN > 1) ? $clog2(N_CNT_IN) : 1;

  logic                          tcr_en, tcr_rst;
  logic [CNT_W-1:0]              pr_q;
  logic [MCR_W-1:0]              mcr_q;
  logic [N_OUT-1:0]              pcr_dbl, pcr_en;
  logic [N_MATCH-1:0]            ler_q;
  cmode_e                        cmode_q;
  logic [SEL_W-1:0]              csel_q;
  logic [IR_W-1:0]               flags, irq_set, irq_clr;

  logic                          ext_edge, tick, ext_mode;
  logic [CNT_W-1:0]              tc, pc;
  logic [N_MATCH-1:0]            match_evt, wr_mr;
  logic [N_MATCH-1:0][CNT_W-1:0] mr_shadow;
  logic                          rst_req, stop_evt, load_evt;
  logic [N_OUT-1:0]              out_state;

  function automatic logic wsel(input logic [AW-1:0] a);
    return we_i && (addr_i == a);
  endfunction

  assign ext_mode = (cmode_q != CM_TIMER);

  always_comb begin
    rst_req  = 1'b0;
    stop_evt = 1'b0;
    for (int n = 0; n < N_MATCH; n++) begin
      rst_req  = rst_req  | (match_evt[n] & mcr_q[3*n+1]);
      stop_evt = stop_evt | (match_evt[n] & mcr_q[3*n+2]);
      wr_mr[n] = wsel(A_MR0 + AW'(n));
    end
  end
  assign load_evt = match_evt[0] & mcr_q[1];

  pwm_cnt_src #(.N_IN(N_CNT_IN), .SEL_W(SEL_W)) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt_in_i),
    .sel_i  (csel_q),
    .mode_i (cmode_q),
    .edge_o (ext_edge)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (tcr_en),
    .hold_i     (tcr_rst),
    .ext_i      (ext_mode),
    .edge_i     (ext_edge),
    .pr_i       (pr_q),
    .rst_req_i  (rst_req),
    .stop_req_i (stop_evt),
    .tick_o     (tick),
    .tc_o       (tc),
    .pc_o       (pc)
  );

  pwm_match_bank #(.CNT_W(CNT_W)) u_mr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_mr),
    .wdata_i  (wdata_i[CNT_W-1:0]),
    .ler_i    (ler_q),
    .load_i   (load_evt),
    .tick_i   (tick),
    .tc_i     (tc),
    .shadow_o (mr_shadow),
    .match_o  (match_evt)
  );

  pwm_out_ctrl u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .match_i (match_evt),
    .dbl_i   (pcr_dbl),
    .en_i    (pcr_en),
    .state_o (out_state),
    .pwm_o   (pwm_o)
  );

  // control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcr_en  <= 1'b0;
      tcr_rst <= 1'b0;
      pr_q    <= '0;
      mcr_q   <= '0;
      pcr_dbl <= '0;
      pcr_en  <= '0;
      ler_q   <= '0;
      cmode_q <= CM_TIMER;
      csel_q  <= '0;
    end else begin
      if (wsel(A_TCR)) begin
        tcr_en  <= wdata_i[0];
        tcr_rst <= wdata_i[1];
      end else if (stop_evt) begin
        tcr_en  <= 1'b0;
      end
      if (wsel(A_PR))  pr_q  <= wdata_i[CNT_W-1:0];
      if (wsel(A_MCR)) mcr_q <= wdata_i[MCR_W-1:0];
      if (wsel(A_PCR)) begin
        pcr_dbl <= wdata_i[N_OUT-1:0];
        pcr_en  <= wdata_i[8 +: N_OUT];
      end
      if (wsel(A_LER))   ler_q <= wdata_i[N_MATCH-1:0];
      else if (load_evt) ler_q <= '0;
      if (wsel(A_CTCR)) begin
        cmode_q <= cmode_e'(wdata_i[1:0]);
        csel_q  <= wdata_i[2 +: SEL_W];
      end
    end
  end

  // interrupt flags
  always_comb begin
    irq_set = '0;
    for (int n = 0; n < N_MATCH; n++)
      irq_set[irq_pos(n)] = match_evt[n] & mcr_q[3*n];
    irq_set[4] = cap_i[0];
    irq_set[5] = cap_i[1];
  end
  assign irq_clr = wsel(A_IR) ? wdata_i[IR_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags <= '0;
    else         flags <= (flags & ~irq_clr) | irq_set;
  end
  assign irq_o = |flags;

  // read mux
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_IR:    rdata_o = DW'(flags);
      A_TCR:   rdata_o = DW'({tcr_rst, tcr_en});
      A_TC:    rdata_o = DW'(tc);
      A_PR:    rdata_o = DW'(pr_q);
      A_PC:    rdata_o = DW'(pc);
      A_MCR:   rdata_o = DW'(mcr_q);
      A_PCR:   rdata_o = DW'({pcr_en, 2'b00, pcr_dbl});
      A_LER:   rdata_o = DW'(ler_q);
      A_CTCR:  rdata_o = DW'({csel_q, logic'(cmode_q[1]), logic'(cmode_q[0])});
      default: begin
        for (int n = 0; n < N_MATCH; n++)
          if (addr_i == A_MR0 + AW'(n)) rdata_o = DW'(mr_shadow[n]);
      end
    endcase
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [AW-1:0]      addr_i,
  input logic [DW-1:0]      wdata_i,
  input logic [N_MATCH-1:0] match_evt,
  input logic [N_OUT-1:0]   out_state,
  input logic [N_OUT-1:0]   pcr_dbl,
  input logic [IR_W-1:0]    flags,
  input logic [IR_W-1:0]    irq_set,
  input logic [N_MATCH-1:0] ler_q,
  input logic               load_evt,
  input logic               stop_evt,
  input logic               tcr_en,
  input logic               tcr_rst,
  input logic [CNT_W-1:0]   tc
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assert_match_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_evt[k+1] |=> !out_state[k]);
    assert_single_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match_evt[0] && !pcr_dbl[k] && !match_evt[k+1]) |=> out_state[k]);
    assert_double_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match_evt[k] && pcr_dbl[k] && !match_evt[k+1]) |=> out_state[k]);
  end

  for (genvar b = 0; b < IR_W; b++) begin : g_ir
    assert_flag_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_set[b] |=> flags[b]);
    assert_flag_w1c_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_IR && wdata_i[b] && !irq_set[b]) |=> !flags[b]);
  end

  assert_ler_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_evt && !(we_i && addr_i == A_LER)) |=> (ler_q == '0));

  assert_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_evt && !(we_i && addr_i == A_TCR)) |=> !tcr_en);

  assert_hold_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tcr_rst |=> (tc == '0));
endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .match_evt (match_evt),
  .out_state (out_state),
  .pcr_dbl   (pcr_dbl),
  .flags     (flags),
  .irq_set   (irq_set),
  .ler_q     (ler_q),
  .load_evt  (load_evt),
  .stop_evt  (stop_evt),
  .tcr_en    (tcr_en),
  .tcr_rst   (tcr_rst),
  .tc        (tc)
);

// File: tb/pwm_timer_bench.sv
`timescale 1ns/1ps
module pwm_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  cnt_in_i = '0;
  logic [1:0]  cap_i = '0;
  logic [5:0]  pwm_o;
  logic        irq_o;

  localparam int K_RD = 0, K_DUTY = 1, K_IRQ = 2, K_PWM = 3;

  int n_chk = 0, n_fail = 0;
  bit busy = 1'b0;
  bit done = 1'b0;
  int          kq[$];
  int          iq[$];
  int          wq[$];
  logic [31:0] eq[$];
  string       rq[$];

  always #10 clk_i = ~clk_i;

  pwm_timer u_pwm_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .cnt_in_i (cnt_in_i),
    .cap_i    (cap_i),
    .pwm_o    (pwm_o),
    .irq_o    (irq_o)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: pops expected items and compares at negedges
  initial begin
    forever begin
      @(negedge clk_i);
      if (kq.size() > 0) begin
        int k, idx, win, cnt;
        logic [31:0] e, act;
        string r;
        busy = 1'b1;
        k = kq.pop_front(); idx = iq.pop_front(); win = wq.pop_front();
        e = eq.pop_front(); r = rq.pop_front();
        act = '0;
        case (k)
          K_RD:  act = rdata_o;
          K_IRQ: act = {31'b0, irq_o};
          K_PWM: act = {26'b0, pwm_o};
          default: begin
            cnt = 0;
            for (int i = 0; i < win; i++) begin
              if (i > 0) @(negedge clk_i);
              cnt += int'(pwm_o[idx]);
            end
            act = 32'(cnt);
          end
        endcase
        n_chk++;
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, e);
        end
        busy = 1'b0;
      end
    end
  end

  task automatic idle();
    while (kq.size() != 0 || busy) @(negedge clk_i);
  endtask

  task automatic push(input int k, input int idx, input int win,
                      input logic [31:0] e, input string r);
    @(posedge clk_i);
    kq.push_back(k); iq.push_back(idx); wq.push_back(win);
    eq.push_back(e); rq.push_back(r);
    idle();
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic chk_rd(input logic [4:0] a, input logic [31:0] e, input string r);
    @(negedge clk_i);
    addr_i = a;
    push(K_RD, 0, 0, e, r);
  endtask

  // output k (1..6) high-cycle count over win cycles
  task automatic chk_duty(input int k, input int win, input int e, input string r);
    push(K_DUTY, k - 1, win, 32'(e), r);
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse(input int b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); cnt_in_i[b] = 1'b1;
      gap(4);
      cnt_in_i[b] = 1'b0;
      gap(4);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    gap(3);
    rst_ni = 1'b1;
    gap(2);
    // R1 reset state
    chk_rd(5'd0, 32'h0, "R1 flags reset");
    chk_rd(5'd2, 32'h0, "R1 counter reset");
    chk_rd(5'd16, 32'h0, "R1 shadow reset");
    push(K_PWM, 0, 0, 32'h0, "R1 pwm reset");
    push(K_IRQ, 0, 0, 32'h0, "R1 irq reset");

    // configure: period 10 ticks, PR=0
    wr(5'd16, 9); wr(5'd17, 3); wr(5'd18, 2); wr(5'd19, 7);
    wr(5'd20, 1); wr(5'd21, 5); wr(5'd22, 8);
    chk_rd(5'd19, 32'd7, "R1 shadow readback");
    wr(5'd7, 32'h7F);
    wr(5'd5, 32'h2);                 // match 0 resets
    wr(5'd6, 32'h1F00 | 32'h34);     // enable 1..5, double on 3,5,6
    wr(5'd3, 0);
    wr(5'd1, 1);
    gap(30);
    chk_rd(5'd7, 32'h0, "R9 load enable self-clears");
    chk_duty(1, 100, 40, "R6 single out1");
    chk_duty(2, 100, 30, "R6 single out2");
    chk_duty(3, 100, 50, "R7 double out3");
    chk_duty(4, 100, 20, "R5 single out4 cleared by match4");
    chk_duty(5, 100, 40, "R7 double out5 set by match4");
    chk_duty(6, 100, 0,  "R8 disabled out6 stays low");
    wr(5'd6, 32'h3F00 | 32'h34);
    gap(2);
    chk_duty(6, 100, 30, "R7 double out6 set by match5 cleared by match6");
    wr(5'd6, 32'h3F00 | 32'h30);
    gap(30);
    chk_duty(3, 100, 80, "R6 out3 back to single edge");

    // shadow only takes effect after load enable
    wr(5'd17, 6);
    gap(30);
    chk_duty(1, 100, 40, "R9 shadow write without load enable");
    chk_rd(5'd17, 32'd6, "R1 shadow holds new value");
    wr(5'd7, 32'h2);
    gap(30);
    chk_duty(1, 100, 70, "R9 value active after load enable");
    chk_rd(5'd7, 32'h0, "R9 load enable cleared");

    // prescaler
    wr(5'd3, 2);
    gap(100);
    chk_duty(1, 300, 210, "R3 prescale limit 2");
    wr(5'd3, 0);
    gap(30);

    // interrupts
    wr(5'd5, 32'h2 | (32'h1 << 3) | (32'h1 << 12) | (32'h1 << 18));
    gap(20);
    wr(5'd5, 32'h2);
    chk_rd(5'd0, 32'h502, "R11 match1/4/6 flags at bits 1,8,10");
    push(K_IRQ, 0, 0, 32'h1, "R11 irq high");
    @(negedge clk_i); cap_i = 2'b01;
    @(negedge clk_i); cap_i = 2'b00;
    chk_rd(5'd0, 32'h512, "R11 capture0 at bit 4");
    wr(5'd0, 32'h0);
    chk_rd(5'd0, 32'h512, "R12 write zero no effect");
    wr(5'd0, 32'h12);
    chk_rd(5'd0, 32'h500, "R12 write one clears");
    wr(5'd0, 32'h500);
    chk_rd(5'd0, 32'h0, "R12 all cleared");
    push(K_IRQ, 0, 0, 32'h0, "R11 irq low");
    @(negedge clk_i); cap_i = 2'b11;
    @(negedge clk_i); cap_i = 2'b00;
    chk_rd(5'd0, 32'h030, "R11 capture bits, reserved stay 0");
    wr(5'd0, 32'hFFFF_FFFF);
    chk_rd(5'd0, 32'h0, "R12 clear captures");

    // stop on match 1 (active 6)
    wr(5'd5, 32'h22);
    wr(5'd1, 2);
    wr(5'd1, 1);
    gap(30);
    chk_rd(5'd2, 32'd6, "R4 counter held at stop value");
    chk_rd(5'd1, 32'h0, "R4 enable cleared by stop");

    // counter mode
    wr(5'd5, 32'h2);
    wr(5'd1, 2);
    gap(2);
    chk_rd(5'd2, 32'h0, "R2 hold reset clears counter");
    wr(5'd8, 32'h5);
    wr(5'd1, 1);
    gap(20);
    chk_rd(5'd2, 32'h0, "R10 no edges no count");
    pulse(1, 3);
    pulse(0, 2);
    gap(6);
    chk_rd(5'd2, 32'd3, "R10 rising edges on input 1");
    wr(5'd1, 2); wr(5'd8, 32'h6); wr(5'd1, 1);
    pulse(1, 3);
    gap(6);
    chk_rd(5'd2, 32'd3, "R10 falling edges");
    wr(5'd1, 2); wr(5'd8, 32'h7); wr(5'd1, 1);
    pulse(1, 3);
    gap(6);
    chk_rd(5'd2, 32'd6, "R10 both edges");
    wr(5'd1, 2); wr(5'd8, 32'h1); wr(5'd1, 1);
    pulse(1, 2);
    gap(6);
    chk_rd(5'd2, 32'd0, "R10 unselected input ignored");
    pulse(0, 2);
    gap(6);
    chk_rd(5'd2, 32'd2, "R10 input 0 selected");

    done = 1'b1;
    summary();
  end
endmodule